// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

A single-channel data mover that copies bytes from a source region to a destination region through a 64-bit read/write memory port. A packed 32-bit configuration word sets its behaviour. For each pointer, the word picks whether the pointer holds still, walks upward or walks downward, and picks a step of 1, 2, 4 or 8 bytes. The same word gives the buffer length and chooses what one peripheral request launches: one buffer, one whole block, or a block played back several times.

Every data transfer is a read of one beat followed by a write of that beat. A beat carries as many bytes as the source step, cut short when the block or the buffer has fewer bytes left. When a unit of work ends, the channel acknowledges the request. It does this either with a one-cycle pulse or by writing a programmed 32-bit word to a programmed address. Once a block has fully drained, a one-cycle done interrupt follows. A request that arrives while the channel is working is held and served afterwards. The channel latches a two-bit priority and presents it to an outside arbiter.

Top module: `dma_chan_seq`

## Requirements
- R1: Configuration bits [1:0] set the source pointer mode: 00 fixed, 10 add the source step after each data transfer, 11 subtract it. Code 01 behaves as fixed.
- R2: Configuration bits [3:2] set the destination pointer mode with the same codes as R1. The pointer steps by the destination step after each data transfer.
- R3: Bits [9:8] (source) and [11:10] (destination) pick the step size: codes 0,1,2,3 mean 1,2,4,8 bytes. A beat carries the source step in bytes. Read data byte i belongs to address+i, and write byte i goes to address+i.
- R4: When fewer bytes remain in the block, or in the current buffer in buffer mode, than the source step, the beat carries only the remaining bytes.
- R5: Trigger code 00 (bits [29:28]): each request moves min(buffer length, bytes left in block). The buffer length is bits [25:18] plus one, and any field value above 127 means 128. The next request resumes where the last one stopped.
- R6: Trigger code 01: each request moves the whole block of `blk_len` bytes (1 to 65536).
- R7: Trigger code 10: each request moves the block `rpt_cnt`+1 times. Both pointers return to their base addresses before each pass. One acknowledge and one done interrupt follow the last pass.
- R8: Trigger code 11 is unsupported. The request sets the sticky `err` output and causes no memory access and no acknowledge.
- R9: At the end of each unit of work, if `ack_sel` is 0, `ack_pulse` is high for exactly one cycle. If `ack_sel` is 1, there is no pulse; instead a single 4-byte write of `ack_data` goes to `ack_addr`.
- R10: Each beat's read is accepted before its write is issued. Read and write are never active together. A request is held with a stable address until `mem_ready`.
- R11: A request arriving while the channel is busy is kept pending and served after the current unit. Several such requests collapse into one.
- R12: `done_irq` is a one-cycle pulse given only when a block has fully completed, one cycle after its acknowledge ends.
- R13: `prio_out` shows the `prio_in` value latched when the current unit started (00 low, 01 medium, 10 high, 11 very high).
- R14: After reset, no memory access, acknowledge, interrupt or error is active, `busy` is low and `prio_out` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg | input | 32 | Packed channel configuration word |
| prio_in | input | 2 | Priority level to latch |
| src_base | input | AW | Source start address |
| dst_base | input | AW | Destination start address |
| blk_len | input | BLKW | Block length in bytes |
| rpt_cnt | input | RPTW | Extra block passes in repeat mode |
| ack_sel | input | 1 | 0: pulse acknowledge, 1: register-write acknowledge |
| ack_addr | input | AW | Acknowledge write address |
| ack_data | input | 32 | Acknowledge write value |
| req | input | 1 | Peripheral request strobe |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | AW | Access byte address |
| mem_wdata | output | 64 | Write data, byte 0 at mem_addr |
| mem_bytes | output | 4 | Bytes in this access (1 to 8) |
| mem_rdata | input | 64 | Read data, byte 0 from mem_addr |
| mem_ready | input | 1 | Access accepted this cycle |
| ack_pulse | output | 1 | One-cycle request acknowledge |
| done_irq | output | 1 | Block-complete interrupt pulse |
| err | output | 1 | Sticky unsupported-mode flag |
| busy | output | 1 | Working or request pending |
| prio_out | output | 2 | Latched priority level |

## Verification
A corrupted pointer or step is seen on `mem_addr` in the very next beat. It leaves misplaced bytes that a whole-memory comparison against an arithmetic model catches once the unit ends. A wrong remaining-byte or buffer count changes the beat size or the number of reads. It shows up as a wrong read count, a wrong byte total, or an acknowledge and interrupt that arrive too early or too late. A lost pending flag or a wrong repeat count shows as a missing or extra unit, which the byte total and acknowledge count reveal within one request.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW   = 32,
  parameter int BLKW = 17,
  parameter int RPTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     cfg,
  input  logic [1:0]      prio_in,
  input  logic [AW-1:0]   src_base,
  input  logic [AW-1:0]   dst_base,
  input  logic [BLKW-1:0] blk_len,
  input  logic [RPTW-1:0] rpt_cnt,
  input  logic            ack_sel,
  input  logic [AW-1:0]   ack_addr,
  input  logic [31:0]     ack_data,
  input  logic            req,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [AW-1:0]   mem_addr,
  output logic [63:0]     mem_wdata,
  output logic [3:0]      mem_bytes,
  input  logic [63:0]     mem_rdata,
  input  logic            mem_ready,
  output logic            ack_pulse,
  output logic            done_irq,
  output logic            err,
  output logic            busy,
  output logic [1:0]      prio_out
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_ACK} st_t;
  localparam logic [1:0] TRG_BUF = 2'b00, TRG_RPT = 2'b10, TRG_LL = 2'b11;

  st_t             st;
  logic            pend, open, irq_pend, ack_q, err_q, done_q;
  logic [1:0]      prio_q;
  logic [11:0]     mode_q;
  logic [1:0]      trig_q;
  logic [AW-1:0]   sp, dp;
  logic [BLKW-1:0] blk_rem;
  logic [7:0]      buf_rem;
  logic [RPTW-1:0] rpt_left;
  logic [63:0]     data_q;

  wire take = (st == S_IDLE) && pend;
  wire [7:0] buf_init = cfg[25] ? 8'd128 : {1'b0, cfg[24:18]} + 8'd1;
  wire [3:0] s_step = 4'd1 << mode_q[9:8];
  wire [3:0] d_step = 4'd1 << mode_q[11:10];

  logic [3:0] beat;
  always_comb begin
    beat = s_step;
    if (blk_rem < BLKW'(s_step)) beat = blk_rem[3:0];
    if (trig_q == TRG_BUF && buf_rem < 8'(beat)) beat = buf_rem[3:0];
  end

  wire [BLKW-1:0] blk_nxt = blk_rem - BLKW'(beat);
  wire [7:0]      buf_nxt = buf_rem - 8'(beat);

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p, input logic [1:0] m,
                                             input logic [3:0] s);
    case (m)
      2'b10:   return p + AW'(s);
      2'b11:   return p - AW'(s);
      default: return p;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pend <= 1'b0; open <= 1'b0; irq_pend <= 1'b0;
      ack_q <= 1'b0; err_q <= 1'b0; done_q <= 1'b0; prio_q <= 2'b00;
      mode_q <= '0; trig_q <= 2'b00; sp <= '0; dp <= '0;
      blk_rem <= '0; buf_rem <= '0; rpt_left <= '0; data_q <= '0;
    end else begin
      pend   <= (pend & ~take) | req;
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          if (cfg[29:28] == TRG_LL) err_q <= 1'b1;
          else begin
            mode_q  <= cfg[11:0];
            trig_q  <= cfg[29:28];
            prio_q  <= prio_in;
            ack_q   <= ack_sel;
            buf_rem <= buf_init;
            if (!open) begin
              blk_rem  <= blk_len;
              sp       <= src_base;
              dp       <= dst_base;
              rpt_left <= rpt_cnt;
              open     <= 1'b1;
            end
            st <= S_RD;
          end
        end
        S_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          st     <= S_WR;
        end
        S_WR: if (mem_ready) begin
          sp      <= step_ptr(sp, mode_q[1:0], s_step);
          dp      <= step_ptr(dp, mode_q[3:2], d_step);
          blk_rem <= blk_nxt;
          buf_rem <= buf_nxt;
          if (blk_nxt == '0) begin
            if (trig_q == TRG_RPT && rpt_left != '0) begin
              rpt_left <= rpt_left - 1'b1;
              blk_rem  <= blk_len;
              sp       <= src_base;
              dp       <= dst_base;
              st       <= S_RD;
            end else begin
              open     <= 1'b0;
              irq_pend <= 1'b1;
              st       <= S_ACK;
            end
          end else if (trig_q == TRG_BUF && buf_nxt == 8'd0) st <= S_ACK;
          else st <= S_RD;
        end
        S_ACK: if (!ack_q || mem_ready) begin
          done_q   <= irq_pend;
          irq_pend <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd    = (st == S_RD);
  assign mem_wr    = (st == S_WR) || (st == S_ACK && ack_q);
  assign mem_addr  = (st == S_RD) ? sp : (st == S_WR) ? dp : ack_addr;
  assign mem_wdata = (st == S_ACK) ? {32'd0, ack_data} : data_q;
  assign mem_bytes = (st == S_ACK) ? 4'd4 : beat;
  assign ack_pulse = (st == S_ACK) && !ack_q;
  assign done_irq  = done_q;
  assign err       = err_q;
  assign busy      = (st != S_IDLE) || pend;
  assign prio_out  = prio_q;

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_bytes,
  input logic          ack_pulse,
  input logic          done_irq,
  input logic          err
);

  // R10
  no_dual_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && !mem_ready |=> mem_rd && $stable(mem_addr));

  // R10
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_ready |=> mem_wr);

  // R3
  beat_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> (mem_bytes != 4'd0 && mem_bytes <= 4'd8));

  // R12
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse |=> !ack_pulse);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
  .ack_pulse(ack_pulse), .done_irq(done_irq), .err(err)
);

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;
  localparam int AW = 32, BLKW = 17, RPTW = 8;
  localparam logic [31:0] ACK_AD = 32'h3F0;

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg = 0;
  logic [1:0] prio_in = 0;
  logic [AW-1:0] src_base = 0, dst_base = 0, ack_addr = ACK_AD;
  logic [BLKW-1:0] blk_len = 1;
  logic [RPTW-1:0] rpt_cnt = 0;
  logic ack_sel = 0, req = 0;
  logic [31:0] ack_data = 32'hA5C31E07;
  logic mem_rd, mem_wr, ack_pulse, done_irq, err, busy;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic [3:0] mem_bytes;
  logic mem_ready = 1;
  logic [1:0] prio_out;

  always #2 clk = ~clk;

  dma_chan_seq #(.AW(AW), .BLKW(BLKW), .RPTW(RPTW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .prio_in(prio_in), .src_base(src_base),
    .dst_base(dst_base), .blk_len(blk_len), .rpt_cnt(rpt_cnt), .ack_sel(ack_sel),
    .ack_addr(ack_addr), .ack_data(ack_data), .req(req), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_bytes(mem_bytes), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .ack_pulse(ack_pulse), .done_irq(done_irq), .err(err), .busy(busy),
    .prio_out(prio_out));

  logic [7:0] mem [0:1023];
  logic [7:0] exp_m [0:1023];
  logic prep = 0;
  int seed = 0;
  int n_rd, n_bytes, n_ackw, n_ackp, n_done;
  int checks = 0, fails = 0, cyc = 0;
  bit stall = 0;
  int rcnt = 0;

  always_comb
    for (int i = 0; i < 8; i++) mem_rdata[8*i +: 8] = mem[mem_addr[9:0] + 10'(i)];

  always @(negedge clk) begin
    rcnt <= rcnt + 1;
    mem_ready <= !stall || (rcnt % 3 != 2);
  end

  always @(posedge clk) begin
    if (prep) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'((i * 37 + seed) ^ (i >> 3));
      n_rd <= 0; n_bytes <= 0; n_ackw <= 0; n_ackp <= 0; n_done <= 0;
    end else begin
      if (mem_wr && mem_ready) begin
        for (int i = 0; i < 8; i++)
          if (i < int'(mem_bytes)) mem[mem_addr[9:0] + 10'(i)] <= mem_wdata[8*i +: 8];
        if (mem_addr == ACK_AD) n_ackw <= n_ackw + 1;
        else n_bytes <= n_bytes + int'(mem_bytes);
      end
      if (mem_rd && mem_ready) n_rd <= n_rd + 1;
      if (ack_pulse) n_ackp <= n_ackp + 1;
      if (done_irq) n_done <= n_done + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint ex);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, ex);
    end
  endtask

  // reference model state
  int m_blk, m_sp, m_dp, m_rpt, e_done, e_bytes, e_beats;
  bit m_open;

  task automatic model_req(input logic [31:0] c);
    int trig, ssz, dsz, sm, dm, bl, brem, n;
    bit fin;
    logic [7:0] tmp [0:7];
    trig = int'(c[29:28]); sm = int'(c[1:0]); dm = int'(c[3:2]);
    ssz = 1 << c[9:8]; dsz = 1 << c[11:10];
    bl = (c[25:18] > 127) ? 128 : int'(c[25:18]) + 1;
    if (trig == 3) return;
    if (!m_open) begin
      m_blk = int'(blk_len); m_sp = int'(src_base); m_dp = int'(dst_base);
      m_rpt = int'(rpt_cnt); m_open = 1;
    end
    brem = bl; fin = 0;
    while (!fin) begin
      n = ssz;
      if (n > m_blk) n = m_blk;
      if (trig == 0 && n > brem) n = brem;
      for (int k = 0; k < n; k++) tmp[k] = exp_m[(m_sp + k) & 1023];
      for (int k = 0; k < n; k++) exp_m[(m_dp + k) & 1023] = tmp[k];
      e_beats++; e_bytes += n;
      if (sm == 2) m_sp += ssz; else if (sm == 3) m_sp -= ssz;
      if (dm == 2) m_dp += dsz; else if (dm == 3) m_dp -= dsz;
      m_blk -= n; brem -= n;
      if (m_blk == 0) begin
        if (trig == 2 && m_rpt != 0) begin
          m_rpt--; m_blk = int'(blk_len); m_sp = int'(src_base); m_dp = int'(dst_base);
        end else begin
          m_open = 0; e_done++; fin = 1;
        end
      end else if (trig == 0 && brem == 0) fin = 1;
    end
    if (ack_sel)
      for (int k = 0; k < 4; k++) exp_m[ACK_AD + k] = ack_data[8*k +: 8];
  endtask

  task automatic restart(input int sd);
    @(negedge clk);
    rst_n = 0; seed = sd; prep = 1;
    @(negedge clk);
    prep = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 1024; i++) exp_m[i] = 8'((i * 37 + sd) ^ (i >> 3));
    m_open = 0; e_done = 0; e_bytes = 0; e_beats = 0;
  endtask

  task automatic fire();
    req = 1;
    @(negedge clk);
    req = 0;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int mismatches();
    int m = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== exp_m[i]) m++;
    return m;
  endfunction

  initial begin
    int reqs;
    restart(1);
    // R14
    chk(!mem_rd && !mem_wr && !ack_pulse && !done_irq && !err && !busy && prio_out == 0,
        "R14 reset state", {mem_rd, mem_wr, ack_pulse, done_irq, err, busy, prio_out}, 0);

    // R1 R2 R3 R4 R6 sweep in block mode
    src_base = 32'h100; dst_base = 32'h200; blk_len = 13;
    for (int sm = 0; sm < 4; sm++)
      for (int dmi = 0; dmi < 3; dmi++)
        for (int ss = 0; ss < 4; ss++)
          for (int dsi = 0; dsi < 2; dsi++) begin
            logic [31:0] c;
            int dm;
            dm = (dmi == 0) ? 0 : dmi + 1;
            c = 32'(sm) | (32'(dm) << 2) | (32'(ss) << 8) | (32'(dsi * 3) << 10) | (32'd1 << 28);
            stall = (ss + sm) % 2 == 1;
            restart(sm * 50 + dm * 9 + ss * 3 + dsi);
            cfg = c;
            model_req(c); fire();
            chk(mismatches() == 0, "R1 R2 R3 R4 memory image", mismatches(), 0);
            chk(n_rd == e_beats, "R3 R4 beat count", n_rd, e_beats);
            chk(n_done == 1, "R6 done count", n_done, 1);
            chk(n_ackp == 1, "R9 ack pulses", n_ackp, 1);
          end
    stall = 0;

    // R5 buffer mode over several buffer lengths
    blk_len = 20;
    for (int bc = 0; bc < 10; bc++) begin
      logic [31:0] c;
      restart(200 + bc);
      c = 32'h0000_010A | (32'(bc) << 18);
      cfg = c; reqs = 0;
      while (e_done == 0 && reqs < 30) begin
        model_req(c); fire(); reqs++;
        chk(n_bytes == e_bytes, "R5 bytes after request", n_bytes, e_bytes);
        chk(n_done == e_done, "R12 done only at block end", n_done, e_done);
      end
      chk(n_ackp == reqs, "R5 R9 one ack per buffer", n_ackp, reqs);
      chk(mismatches() == 0, "R5 memory image", mismatches(), 0);
    end

    // R5 clamp of buffer field above 127
    restart(300);
    blk_len = 300; cfg = 32'h0000_000A | (32'd200 << 18);
    model_req(cfg); fire();
    chk(n_bytes == 128, "R5 clamp to 128", n_bytes, 128);

    // R7 repeated block
    blk_len = 5;
    for (int r = 0; r < 4; r++) begin
      restart(400 + r);
      rpt_cnt = 8'(r); cfg = 32'h2000_000A;
      model_req(cfg); fire();
      chk(n_rd == 5 * (r + 1), "R7 reads over passes", n_rd, 5 * (r + 1));
      chk(n_done == 1 && n_ackp == 1, "R7 one done and ack", n_done * 10 + n_ackp, 11);
      chk(mismatches() == 0, "R7 memory image", mismatches(), 0);
    end
    rpt_cnt = 0;

    // R8 unsupported trigger
    restart(500);
    cfg = 32'h3000_000A; fire();
    chk(err == 1, "R8 error flag", err, 1);
    chk(n_rd == 0 && n_ackp == 0, "R8 no activity", n_rd + n_ackp, 0);

    // R9 register-write acknowledge
    restart(600);
    ack_sel = 1; blk_len = 9; cfg = 32'h1000_010A;
    model_req(cfg); fire();
    chk(n_ackp == 0, "R9 no pulse in write mode", n_ackp, 0);
    chk(n_ackw == 1, "R9 single ack write", n_ackw, 1);
    chk(mismatches() == 0, "R9 ack word in memory", mismatches(), 0);
    ack_sel = 0;

    // R11 requests while busy collapse into one pending
    restart(700);
    blk_len = 40; cfg = 32'h0000_000A | (32'd3 << 18);
    req = 1;
    repeat (3) @(negedge clk);
    req = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(n_bytes == 8, "R11 two buffers moved", n_bytes, 8);
    chk(n_ackp == 2, "R11 two acks", n_ackp, 2);

    // R13 priority latched at unit start
    restart(800);
    blk_len = 40; cfg = 32'h1000_000A; prio_in = 2;
    req = 1;
    @(negedge clk);
    req = 0;
    repeat (3) @(negedge clk);
    prio_in = 1;
    while (busy) @(negedge clk);
    chk(prio_out == 2, "R13 latched priority", prio_out, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule